// File: doc/BRIEF.md
# Step Transition Watchdog Bank

This block supervises the steps of a sequential control program. It has ten channels, and each one watches one step. A channel starts a timed window when its supervision gate opens. The gate is open while the channel enable and the step-active flag are both high. The window length is counted in a one-second tick that the block receives from outside. If the step's transition condition has not been met by the end of the window, the channel latches a timeout. It also presents an alarm number for the alarm logic that sits downstream.

Each channel is configured by one 16-bit setting word. The upper byte is the alarm number and the lower byte is the limit in seconds. The word is captured at the instant timing starts. Software may therefore rewrite the word for the next run while the current run is in progress.

The step sequencer and the alarm list stay outside the block. The block only times each step and reports which alarm should be raised.

Top module: `step_wdt_bank`

## Requirements
- R1: In each channel's 16-bit setting word, bits [15:8] are the alarm number (0..255) and bits [7:0] are the time limit in seconds.
- R2: A channel starts timing on the clock edge at which its gate (enable AND step-active) rises, provided the transition input is low. The count then starts again from zero.
- R3: While running, the channel counts the cycles in which tick_i is high. On the clock edge that registers the limit-th tick, timeout_o goes high and alarm_num_o shows the captured alarm number. Whenever timeout_o is low, alarm_num_o is 0.
- R4: Cycles without a tick do not advance the count, and timeout_o never rises after a cycle in which tick_i was low.
- R5: Before expiry, any of these stops the channel with no timeout: the transition input going high, step-active going low, or enable going low. A new run then needs a fresh rising edge of the gate.
- R6: A timeout is sticky. Step-active going low or the transition input going high leaves timeout_o and alarm_num_o unchanged. Enable going low clears both on the next edge.
- R7: A start that captures a limit of 0 never times out, however many ticks arrive.
- R8: The setting word is captured at start. Changes made while a run is in progress affect neither its limit nor its alarm number.
- R9: Channels are independent: one channel's inputs never change another channel's outputs.
- R10: An active-low reset clears every channel: timeout_o is low and alarm_num_o is 0, including for a channel that had timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, high for one cycle |
| en_i | input | 10 | Per-channel enable |
| step_act_i | input | 10 | Per-channel step-active flag |
| trans_met_i | input | 10 | Per-channel transition condition met |
| setting_i | input | 160 | Setting words; channel c uses bits [16c+15:16c] |
| timeout_o | output | 10 | Per-channel sticky timeout |
| alarm_num_o | output | 80 | Alarm numbers; channel c uses bits [8c+7:8c] |

## Verification
The hardest state to reach is a run in progress whose setting word has been changed after capture. The stimulus changes both fields while ticks are being counted, then counts the remaining ticks against the original limit and checks the original alarm number. A second hard case is a channel held in its stopped state: the transition input is released while the gate stays high. Ticks are then fed to show that no new run begins until the gate falls and rises again.

// File: rtl/step_wdt_pkg.sv
package step_wdt_pkg;
  typedef enum logic [1:0] {
    WD_IDLE    = 2'd0,
    WD_RUN     = 2'd1,
    WD_HOLD    = 2'd2,
    WD_EXPIRED = 2'd3
  } wd_state_e;
endpackage

// File: rtl/step_wdt_cfg.sv
module step_wdt_cfg #(
  parameter int ALARM_W = 8,
  parameter int LIMIT_W = 8,
  localparam int SET_W = ALARM_W + LIMIT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SET_W-1:0]   setting_i,
  output logic               limit_zero_o,
  output logic [ALARM_W-1:0] alarm_o,
  output logic [LIMIT_W-1:0] limit_o
);
  logic [ALARM_W-1:0] alarm_in;
  logic [LIMIT_W-1:0] limit_in;

  assign alarm_in     = setting_i[SET_W-1:LIMIT_W];
  assign limit_in     = setting_i[LIMIT_W-1:0];
  assign limit_zero_o = (limit_in == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_o <= '0;
      limit_o <= '0;
    end else if (load_i) begin
      alarm_o <= alarm_in;
      limit_o <= limit_in;
    end
  end
endmodule

// File: rtl/step_wdt_chan.sv
module step_wdt_chan
  import step_wdt_pkg::*;
#(
  parameter int ALARM_W = 8,
  parameter int LIMIT_W = 8,
  localparam int SET_W = ALARM_W + LIMIT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               en_i,
  input  logic               act_i,
  input  logic               trans_i,
  input  logic [SET_W-1:0]   setting_i,
  output logic               timeout_o,
  output logic [ALARM_W-1:0] alarm_o
);
  wd_state_e          state_q, state_d;
  logic [LIMIT_W-1:0] cnt_q, cnt_d;
  logic               gate, gate_q, start;
  logic               lim_zero;
  logic [ALARM_W-1:0] alarm_q;
  logic [LIMIT_W-1:0] limit_q;
  logic [LIMIT_W-1:0] cnt_inc;

  assign gate    = en_i & act_i;
  assign start   = gate & ~gate_q;
  assign cnt_inc = cnt_q + 1'b1;

  step_wdt_cfg #(.ALARM_W(ALARM_W), .LIMIT_W(LIMIT_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start && state_q == WD_IDLE),
    .setting_i    (setting_i),
    .limit_zero_o (lim_zero),
    .alarm_o      (alarm_q),
    .limit_o      (limit_q)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      WD_IDLE: begin
        cnt_d = '0;
        if (start) state_d = (trans_i || lim_zero) ? WD_HOLD : WD_RUN;
      end
      WD_RUN: begin
        if (!gate) begin
          state_d = WD_IDLE;
          cnt_d   = '0;
        end else if (trans_i) begin
          state_d = WD_HOLD;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_inc == limit_q) state_d = WD_EXPIRED;
          cnt_d = cnt_inc;
        end
      end
      WD_HOLD: begin
        cnt_d = '0;
        if (!gate) state_d = WD_IDLE;
      end
      WD_EXPIRED: begin
        if (!en_i) begin
          state_d = WD_IDLE;
          cnt_d   = '0;
        end
      end
      default: state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gate_q  <= gate;
    end
  end

  assign timeout_o = (state_q == WD_EXPIRED);
  assign alarm_o   = timeout_o ? alarm_q : '0;
endmodule

// File: rtl/step_wdt_bank.sv
module step_wdt_bank #(
  parameter int N_CH    = 10,
  parameter int ALARM_W = 8,
  parameter int LIMIT_W = 8,
  localparam int SET_W = ALARM_W + LIMIT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [N_CH-1:0]         en_i,
  input  logic [N_CH-1:0]         step_act_i,
  input  logic [N_CH-1:0]         trans_met_i,
  input  logic [N_CH*SET_W-1:0]   setting_i,
  output logic [N_CH-1:0]         timeout_o,
  output logic [N_CH*ALARM_W-1:0] alarm_num_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    step_wdt_chan #(.ALARM_W(ALARM_W), .LIMIT_W(LIMIT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .en_i      (en_i[c]),
      .act_i     (step_act_i[c]),
      .trans_i   (trans_met_i[c]),
      .setting_i (setting_i[c*SET_W +: SET_W]),
      .timeout_o (timeout_o[c]),
      .alarm_o   (alarm_num_o[c*ALARM_W +: ALARM_W])
    );
  end
endmodule

// File: rtl/step_wdt_chk.sv
module step_wdt_chk #(
  parameter int N_CH    = 10,
  parameter int ALARM_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic [N_CH-1:0]         en_i,
  input logic [N_CH-1:0]         timeout_o,
  input logic [N_CH*ALARM_W-1:0] alarm_num_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    assert_alarm_zero_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !timeout_o[c] |-> alarm_num_o[c*ALARM_W +: ALARM_W] == '0);

    assert_rise_needs_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!timeout_o[c] && !tick_i) |=> !timeout_o[c]);

    assert_clear_on_disable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[c] |=> !timeout_o[c]);

    assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timeout_o[c] && en_i[c]) |=> timeout_o[c]);

    assert_alarm_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o[c] |=> (!timeout_o[c] || $stable(alarm_num_o[c*ALARM_W +: ALARM_W])));
  end
endmodule

bind step_wdt_bank step_wdt_chk #(.N_CH(N_CH), .ALARM_W(ALARM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .en_i        (en_i),
  .timeout_o   (timeout_o),
  .alarm_num_o (alarm_num_o)
);

// File: tb/tb_step_wdt_bank.sv
`timescale 1ns/1ps
module tb_step_wdt_bank;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [N-1:0] en = '0, act = '0, trans = '0;
  logic [15:0]  set_w [N];
  logic [N*16-1:0] set_flat;
  logic [N-1:0]    tmo;
  logic [N*8-1:0]  alm;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb
    for (int c = 0; c < N; c++) set_flat[c*16 +: 16] = set_w[c];

  step_wdt_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en), .step_act_i(act),
    .trans_met_i(trans), .setting_i(set_flat), .timeout_o(tmo), .alarm_num_o(alm)
  );

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  function automatic int alarm_of(int c);
    return int'(alm[c*8 +: 8]);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic start_ch(int c, logic [7:0] alarm, logic [7:0] lim);
    @(negedge clk);
    set_w[c] = {alarm, lim};
    act[c]   = 1'b1;
    en[c]    = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_ch(int c);
    @(negedge clk);
    en[c] = 1'b0; act[c] = 1'b0; trans[c] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset timeout", int'(tmo), 0);
    chk("R10 reset alarm", int'(alm != '0), 0);
  endtask

  task automatic t_basic();
    start_ch(0, 8'd50, 8'd3);
    ticks(2);
    chk("R3 before limit", tmo[0], 0);
    ticks(1);
    chk("R2 R3 timeout at limit", tmo[0], 1);
    chk("R1 R3 alarm number", alarm_of(0), 50);
    stop_ch(0);
    chk("R6 disable clears", tmo[0], 0);
    chk("R3 alarm zero after clear", alarm_of(0), 0);
  endtask

  task automatic t_no_tick();
    start_ch(1, 8'd9, 8'd2);
    cyc(30);
    chk("R4 no tick no timeout", tmo[1], 0);
    ticks(1);
    chk("R4 one tick", tmo[1], 0);
    ticks(1);
    chk("R4 second tick expires", tmo[1], 1);
    stop_ch(1);
  endtask

  task automatic t_abort_trans();
    start_ch(2, 8'd25, 8'd3);
    ticks(2);
    @(negedge clk) trans[2] = 1'b1;
    ticks(5);
    chk("R5 transition met stops", tmo[2], 0);
    @(negedge clk) trans[2] = 1'b0;
    ticks(5);
    chk("R5 no restart without new gate edge", tmo[2], 0);
    @(negedge clk) en[2] = 1'b0;
    @(negedge clk) en[2] = 1'b1;
    @(negedge clk);
    ticks(2);
    chk("R2 restart counts from zero", tmo[2], 0);
    ticks(1);
    chk("R2 restart expires", tmo[2], 1);
    stop_ch(2);
  endtask

  task automatic t_abort_act();
    start_ch(3, 8'd77, 8'd2);
    ticks(1);
    @(negedge clk) act[3] = 1'b0;
    ticks(4);
    chk("R5 step left stops", tmo[3], 0);
    stop_ch(3);
    start_ch(3, 8'd77, 8'd2);
    ticks(1);
    @(negedge clk) en[3] = 1'b0;
    ticks(4);
    chk("R5 enable drop stops", tmo[3], 0);
    stop_ch(3);
  endtask

  task automatic t_sticky();
    start_ch(4, 8'd99, 8'd1);
    ticks(1);
    chk("R3 limit one", tmo[4], 1);
    @(negedge clk) begin act[4] = 1'b0; trans[4] = 1'b1; end
    ticks(3);
    chk("R6 sticky timeout", tmo[4], 1);
    chk("R6 sticky alarm", alarm_of(4), 99);
    @(negedge clk) en[4] = 1'b0;
    @(negedge clk);
    chk("R6 cleared by enable low", tmo[4], 0);
    stop_ch(4);
  endtask

  task automatic t_zero_limit();
    start_ch(5, 8'd11, 8'd0);
    ticks(300);
    chk("R7 zero limit never expires", tmo[5], 0);
    stop_ch(5);
  endtask

  task automatic t_sample();
    start_ch(6, 8'd7, 8'd4);
    ticks(1);
    @(negedge clk) set_w[6] = {8'd200, 8'd1};
    ticks(2);
    chk("R8 new limit ignored", tmo[6], 0);
    ticks(1);
    chk("R8 original limit", tmo[6], 1);
    chk("R8 original alarm", alarm_of(6), 7);
    stop_ch(6);
  endtask

  task automatic t_indep();
    start_ch(7, 8'd151, 8'd2);
    start_ch(8, 8'd210, 8'd5);
    ticks(2);
    chk("R9 ch7 expired", tmo[7], 1);
    chk("R9 ch8 still running", tmo[8], 0);
    chk("R9 other channels idle", int'(tmo & ~(10'b1 << 7)), 0);
    @(negedge clk) en[7] = 1'b0;
    ticks(3);
    chk("R9 ch8 expired", tmo[8], 1);
    chk("R9 ch8 alarm", alarm_of(8), 210);
    chk("R9 ch7 cleared alone", tmo[7], 0);
    stop_ch(7);
    stop_ch(8);
  endtask

  task automatic t_reset_mid();
    start_ch(9, 8'd65, 8'd1);
    ticks(1);
    chk("R3 ch9 expired", tmo[9], 1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears timeout", tmo[9], 0);
    chk("R10 reset clears alarm", alarm_of(9), 0);
    rst_n = 1'b1;
    stop_ch(9);
  endtask

  initial begin
    for (int c = 0; c < N; c++) set_w[c] = 16'h0000;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_basic();
    t_no_tick();
    t_abort_trans();
    t_abort_act();
    t_sticky();
    t_zero_limit();
    t_sample();
    t_indep();
    t_reset_mid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule